// File: doc/BRIEF.md
# Four-Channel Byte DMA Address and Count Engine

This block holds the per-channel address and count state of a four-channel, 8-bit DMA engine that moves one byte per request. A host programs it through a byte-wide register port. Each channel has a 16-bit base and current address, a 16-bit base and current count, a page register that supplies the upper memory address bits, and a small mode field. The 16-bit values are loaded one byte at a time through a shared low/high byte pointer.

A peripheral raises its request line. The engine grants the highest-priority unmasked channel for exactly one cycle. During that cycle it drives the memory address, the transfer direction strobe, a one-hot acknowledge and, on the channel's final byte, a terminal-count pulse. It then steps the channel's address and count. At the end of a block it either reloads the channel from its base registers or masks the channel, depending on that channel's mode.

Top module: `dma4_engine`

## Requirements
- R1: After reset, all four channels are masked, no acknowledge is driven, the byte pointer selects the low byte, and the terminal-count bits of the status register read as zero.
- R2: Each read or write at host offsets 0x00-0x07 toggles one shared byte pointer: the first access targets bits 7:0 and the next targets bits 15:8. Any write to offset 0x0C returns the pointer to the low byte.
- R3: Offset 2c holds the address of channel c and offset 2c+1 holds its count. A write loads both the base and the current register. A read returns the current value.
- R4: A write to 0x0A uses data bits 1:0 as the channel and bit 2 as the mask (1 = masked, 0 = enabled). Any write to 0x0B enables all four channels. A masked channel's request is never acknowledged.
- R5: Channel 0 has the highest priority and channel 3 the lowest. Each grant drives a one-hot acknowledge for exactly one cycle and moves one byte. At least one cycle with no acknowledge separates two grants.
- R6: The memory address is {page, current address}, with the page of channel c written at 0x10+c. A mode write to 0x09 takes the channel from data bits 1:0. Data bit 5 = 1 makes the address increment after each byte, and 0 makes it decrement. The 16-bit address wraps without changing the page.
- R7: Mode data bits 3:2 select the transfer type. 01 asserts mem_wr, 10 asserts mem_rd, and 00 (verify) asserts neither, while the address and count still step.
- R8: A count value N moves N+1 bytes. tc is high during the transfer in which the current count is zero.
- R9: At terminal count, a channel whose mode data bit 4 is 1 reloads its current address and count from the base registers and stays enabled. Otherwise its mask bit is set.
- R10: A read of offset 0x08 returns {dreq[3:0], tc_flags[3:0]}. A tc_flags bit is set at the terminal count of its channel, and every status read clears the flags. A flag set in the same cycle as a status read survives the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsel | input | 1 | Host access strobe, one cycle per access |
| hwr | input | 1 | 1 = write, 0 = read |
| haddr | input | 5 | Host register offset |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Host read data (combinational from haddr) |
| dreq | input | 4 | Per-channel transfer requests |
| dack | output | 4 | One-hot acknowledge of the active transfer |
| mem_addr | output | PAGE_W+16 | Memory byte address |
| mem_wr | output | 1 | Transfer writes memory |
| mem_rd | output | 1 | Transfer reads memory |
| tc | output | 1 | Final transfer of the active channel |

## Verification
Two events can fall in the same cycle: a host read of the status register, which clears the terminal-count flags, and the final transfer of a channel, which sets one of those flags. The bench arranges the collision by issuing the status read during the cycle in which the last byte of channel 0 is acknowledged. It expects that read to return the flags as they stood before the transfer, and the next status read to still show channel 0's flag. A wrong order of the clear and the set would lose that flag.

// File: rtl/dma4_engine.sv
module dma4_engine #(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hwr,
  input  logic [4:0]        haddr,
  input  logic [7:0]        hwdata,
  output logic [7:0]        hrdata,
  input  logic [3:0]        dreq,
  output logic [3:0]        dack,
  output logic [PAGE_W+15:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic              tc
);
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic [AW-1:0]     base_a [NCH];
  logic [AW-1:0]     cur_a  [NCH];
  logic [AW-1:0]     base_c [NCH];
  logic [AW-1:0]     cur_c  [NCH];
  logic [PAGE_W-1:0] page   [NCH];
  logic [3:0]        mode   [NCH];
  logic [3:0]        mask, tcflag;
  logic              ff, busy;
  logic [1:0]        ch, pick;
  logic [AW-1:0]     sel_w;
  logic              unused_bits;

  wire [3:0] req     = dreq & ~mask;
  wire       hw      = hsel & hwr;
  wire       wordsel = hsel && (haddr[4:3] == 2'b00);
  wire [1:0] rc      = haddr[2:1];
  wire       last    = busy && (cur_c[ch] == '0);
  wire [3:0] tc_set  = last ? (4'b0001 << ch) : 4'b0000;
  wire       st_rd   = hsel && !hwr && (haddr == 5'h08);

  assign unused_bits = ^hwdata[7:6];

  always_comb begin
    if (req[0])      pick = 2'd0;
    else if (req[1]) pick = 2'd1;
    else if (req[2]) pick = 2'd2;
    else             pick = 2'd3;
  end

  assign dack     = busy ? (4'b0001 << ch) : 4'b0000;
  assign mem_addr = {page[ch], cur_a[ch]};
  assign mem_wr   = busy && (mode[ch][1:0] == 2'b01);
  assign mem_rd   = busy && (mode[ch][1:0] == 2'b10);
  assign tc       = last;

  always_comb begin
    sel_w  = haddr[0] ? cur_c[rc] : cur_a[rc];
    hrdata = 8'h00;
    if (haddr[4:3] == 2'b00)       hrdata = ff ? sel_w[15:8] : sel_w[7:0];
    else if (haddr == 5'h08)       hrdata = {dreq, tcflag};
    else if (haddr[4:2] == 3'b100) hrdata = 8'(page[haddr[1:0]]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        cur_a[i]  <= '0;
        base_c[i] <= '0;
        cur_c[i]  <= '0;
        page[i]   <= '0;
        mode[i]   <= '0;
      end
      mask   <= 4'hF;
      tcflag <= 4'h0;
      ff     <= 1'b0;
      busy   <= 1'b0;
      ch     <= 2'd0;
    end else begin
      tcflag <= (st_rd ? 4'h0 : tcflag) | tc_set;
      if (busy) begin
        busy      <= 1'b0;
        cur_c[ch] <= cur_c[ch] - 16'd1;
        cur_a[ch] <= mode[ch][3] ? cur_a[ch] + 16'd1 : cur_a[ch] - 16'd1;
        if (last) begin
          if (mode[ch][2]) begin
            cur_a[ch] <= base_a[ch];
            cur_c[ch] <= base_c[ch];
          end else begin
            mask[ch] <= 1'b1;
          end
        end
      end else if (|req) begin
        busy <= 1'b1;
        ch   <= pick;
      end

      if (wordsel) ff <= ~ff;

      if (hw) begin
        if (wordsel) begin
          if (!haddr[0]) begin
            if (ff) begin
              base_a[rc][15:8] <= hwdata;
              cur_a[rc][15:8]  <= hwdata;
            end else begin
              base_a[rc][7:0]  <= hwdata;
              cur_a[rc][7:0]   <= hwdata;
            end
          end else begin
            if (ff) begin
              base_c[rc][15:8] <= hwdata;
              cur_c[rc][15:8]  <= hwdata;
            end else begin
              base_c[rc][7:0]  <= hwdata;
              cur_c[rc][7:0]   <= hwdata;
            end
          end
        end
        if (haddr == 5'h09) mode[hwdata[1:0]] <= hwdata[5:2];
        if (haddr == 5'h0A) mask[hwdata[1:0]] <= hwdata[2];
        if (haddr == 5'h0B) mask <= 4'h0;
        if (haddr == 5'h0C) ff <= 1'b0;
        if (haddr[4:2] == 3'b100) page[haddr[1:0]] <= hwdata[PAGE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dma4_checks.sv
module dma4_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       hsel,
  input logic       hwr,
  input logic [4:0] haddr,
  input logic [7:0] hrdata,
  input logic [3:0] dreq,
  input logic [3:0] dack,
  input logic       mem_wr,
  input logic       mem_rd,
  input logic       tc
);
  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  assert_ack_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |=> (dack == 4'b0000));

  assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> ((dack & $past(dreq)) != 4'b0000));

  assert_dir_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  assert_strobe_in_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> (|dack));

  assert_tc_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (|dack));

  assert_tc_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> (!(hsel && !hwr && haddr == 5'h08) || ((hrdata[3:0] & $past(dack)) != 4'b0000)));
endmodule

bind dma4_engine dma4_checks u_chk (
  .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwr(hwr), .haddr(haddr),
  .hrdata(hrdata), .dreq(dreq), .dack(dack), .mem_wr(mem_wr),
  .mem_rd(mem_rd), .tc(tc)
);

// File: tb/sim_dma4_engine.sv
module sim_dma4_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0, hwr = 1'b0;
  logic [4:0]  haddr = '0;
  logic [7:0]  hwdata = '0;
  logic [7:0]  hrdata;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack;
  logic [19:0] mem_addr;
  logic        mem_wr, mem_rd, tc;
  int          nvec = 0, nbad = 0;
  logic [7:0]  rv;

  always #2 clk = ~clk;

  dma4_engine u0 (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwr(hwr), .haddr(haddr),
    .hwdata(hwdata), .hrdata(hrdata), .dreq(dreq), .dack(dack),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .tc(tc)
  );

  localparam int NV = 17;
  localparam logic [13:0] VEC [NV] = '{
    14'h2234, 14'h2212, 14'h2302, 14'h2300, 14'h3105,
    14'h0234, 14'h0212, 14'h0302, 14'h0300, 14'h1105,
    14'h22AA, 14'h2C00, 14'h2234, 14'h2C00, 14'h0234, 14'h0212,
    14'h0800
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); hsel = 1'b1; hwr = 1'b1; haddr = a; hwdata = d;
    @(negedge clk); hsel = 1'b0; hwr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); hsel = 1'b1; hwr = 1'b0; haddr = a;
    #1 d = hrdata;
    @(negedge clk); hsel = 1'b0;
  endtask

  task automatic xfer(input int c, input logic [19:0] ea, input logic [2:0] wrt, input string tag);
    @(negedge clk); dreq[c] = 1'b1;
    @(negedge clk);
    chk({tag, " dack"}, 32'(dack), 32'(4'b0001 << c));
    chk({tag, " addr"}, 32'(mem_addr), 32'(ea));
    chk({tag, " wr/rd/tc"}, 32'({mem_wr, mem_rd, tc}), 32'(wrt));
    dreq[c] = 1'b0;
    @(negedge clk);
    chk({tag, " idle after grant R5"}, 32'(dack), 32'h0);
  endtask

  task automatic no_ack(input int c, input string tag);
    @(negedge clk); dreq[c] = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(tag, 32'(dack), 32'h0);
    end
    dreq[c] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 dack after reset", 32'(dack), 32'h0);
    rd(5'h08, rv); chk("R1 status after reset", 32'(rv), 32'h00);
    no_ack(1, "R1 channel masked after reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][13]) wr(VEC[i][12:8], VEC[i][7:0]);
      else begin
        rd(VEC[i][12:8], rv);
        chk($sformatf("R2 R3 table vector %0d", i), 32'(rv), 32'(VEC[i][7:0]));
      end
    end

    @(negedge clk); dreq[3] = 1'b1;
    rd(5'h08, rv); chk("R10 pending request bit", 32'(rv), 32'h80);
    chk("R4 masked channel 3 idle", 32'(dack), 32'h0);
    dreq[3] = 1'b0;

    wr(5'h09, 8'h25); wr(5'h0A, 8'h01);
    xfer(1, 20'h51234, 3'b100, "R6 R7 ch1 byte0");
    xfer(1, 20'h51235, 3'b100, "R6 ch1 byte1");
    xfer(1, 20'h51236, 3'b101, "R8 ch1 byte2");
    no_ack(1, "R9 ch1 masked after tc");
    rd(5'h08, rv); chk("R10 tc flag ch1", 32'(rv), 32'h02);
    rd(5'h08, rv); chk("R10 cleared by read", 32'(rv), 32'h00);

    wr(5'h0C, 8'h00);
    wr(5'h00, 8'hFF); wr(5'h00, 8'hFF); wr(5'h01, 8'h01); wr(5'h01, 8'h00);
    wr(5'h10, 8'h03); wr(5'h09, 8'h38);
    wr(5'h04, 8'h10); wr(5'h04, 8'h00); wr(5'h05, 8'h00); wr(5'h05, 8'h00);
    wr(5'h12, 8'h0A); wr(5'h09, 8'h02);
    wr(5'h0B, 8'h00);

    @(negedge clk); dreq[0] = 1'b1; dreq[2] = 1'b1;
    @(negedge clk);
    chk("R5 priority ch0 first", 32'(dack), 32'h1);
    chk("R6 ch0 addr", 32'(mem_addr), 32'h3FFFF);
    chk("R7 ch0 read type", 32'({mem_wr, mem_rd, tc}), 32'h2);
    dreq[0] = 1'b0;
    @(negedge clk);
    chk("R5 gap between grants", 32'(dack), 32'h0);
    @(negedge clk);
    chk("R5 ch2 next", 32'(dack), 32'h4);
    chk("R6 ch2 addr", 32'(mem_addr), 32'hA0010);
    chk("R7 R8 ch2 verify single byte", 32'({mem_wr, mem_rd, tc}), 32'h1);
    dreq[2] = 1'b0;
    @(negedge clk);

    wr(5'h0C, 8'h00);
    rd(5'h04, rv); chk("R6 ch2 decrement low", 32'(rv), 32'h0F);
    rd(5'h04, rv); chk("R6 ch2 decrement high", 32'(rv), 32'h00);

    xfer(0, 20'h30000, 3'b011, "R6 R8 ch0 wrap in page");
    xfer(0, 20'h3FFFF, 3'b010, "R9 ch0 autoinit reload");
    rd(5'h08, rv); chk("R10 flags ch0 ch2", 32'(rv), 32'h05);

    @(negedge clk); dreq[0] = 1'b1;
    @(negedge clk);
    dreq[0] = 1'b0; hsel = 1'b1; hwr = 1'b0; haddr = 5'h08;
    #1;
    chk("R10 status read during tc", 32'(hrdata), 32'h00);
    chk("R8 tc on final byte", 32'(tc), 32'h1);
    @(negedge clk); hsel = 1'b0;
    rd(5'h08, rv); chk("R10 set wins over clear", 32'(rv), 32'h01);

    wr(5'h0A, 8'h04);
    no_ack(0, "R4 single mask ch0");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule